// File: doc/BRIEF.md
# SPI User-Mode Dummy-Byte Injector

This block sits between a register-level write path and an SPI byte shifter. When software drives a flash transaction by hand (user mode), it writes the opcode and address bytes itself, 1 to 4 bytes per write. Some flash read commands need a run of dummy bytes between the address and the data. This block produces those dummy bytes on its own. Software does not have to know how many a given command needs.

Tracking is armed by a chip-select control event that leaves the stop bit clear. The first byte written after that is decoded as an opcode. The block then counts the address bytes that follow. The address length is 3 bytes, or 4 when the extended-addressing input is high. The next write after the address phase is taken to be software's own dummy write, and it is dropped. In its place the block emits `units x 8` copies of the dummy-fill byte, and then stops tracking. When tracking is off, every written byte goes to the shifter unchanged, least-significant byte first, one byte per handshake.

Top module: `spiDummyInject`

## Requirements
- R1: After reset, `txValid` and `swallow` are low and `wrReady` is high. Tracking is off, so no write is dropped until a chip-select event arms it.
- R2: A write that is passed through produces exactly `wrSize` bytes (1 to 4) on `txByte`, starting with bits [7:0] and moving up one byte at a time.
- R3: A `csWrite` with `ceStop` low arms tracking at index 0. A `csWrite` with `ceStop` high disarms it. While disarmed, no write is dropped.
- R4: Opcodes 0x03, 0x13, 0x02, 0x12, 0x32, 0x34 and any opcode not listed in R5 need no dummies. Tracking turns off at once, and every later write passes.
- R5: Opcodes 0x0B, 0x0C, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB and 0xBC need 1 dummy unit. Opcodes 0xEB and 0xEC need 3. One unit is 8 dummy bytes.
- R6: The tracking index is set to the opcode write's size. It then grows by the size of each later write. It does so until it reaches 4 when `extAddr` is low, or 5 when `extAddr` is high.
- R7: The first write accepted once the index has reached that limit is dropped. `swallow` is high in its accept cycle. All its dummy bytes are then emitted with the `dummyByte` value sampled at acceptance, and tracking turns off.
- R8: While `txValid` is high and `txReady` is low, `txByte` holds. `wrReady` is low while any byte is pending and while `csWrite` is high.
- R9: The opcode write and the address writes are themselves passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csWrite | input | 1 | One-cycle chip-select control event |
| ceStop | input | 1 | Stop bit carried by the chip-select event (1 = deselect) |
| extAddr | input | 1 | 4-byte addressing when high, 3-byte when low |
| dummyByte | input | 8 | Fill value for injected dummy bytes |
| wrValid | input | 1 | User-mode write request |
| wrData | input | 32 | Write data, lowest byte sent first |
| wrSize | input | 3 | Byte count of the write, 1 to 4 |
| wrReady | output | 1 | Write accepted when high together with `wrValid` |
| swallow | output | 1 | High in the accept cycle of a dropped write |
| txValid | output | 1 | Byte available for the shifter |
| txByte | output | 8 | Byte for the shifter |
| txReady | input | 1 | Shifter takes the byte when high with `txValid` |

## Verification
The checks assume that `wrSize` is always between 1 and 4 whenever `wrValid` is high, and that `wrData` and `wrSize` hold steady until the write is accepted. The stimulus makes writes only with legal sizes. It holds each request until `wrReady` is seen, and it raises `csWrite` only between writes. Backpressure on `txReady` comes from a fixed pattern, so the hold rule for `txByte` is exercised during both pass-through and injection.

// File: rtl/injPkg.sv
package injPkg;
  localparam int DUMMY_MULT = 8;
  localparam int MAX_UNITS  = 3;
  localparam int CNT_W      = $clog2(MAX_UNITS * DUMMY_MULT + 1);
  localparam int SIZE_W     = 3;

  typedef struct packed {
    logic              loadPass;
    logic              loadInject;
    logic [SIZE_W-1:0] size;
    logic [7:0]        fill;
    logic [CNT_W-1:0]  count;
  } injStrobe_t;

  function automatic logic [1:0] opcodeUnits(input logic [7:0] op);
    case (op)
      8'h0B, 8'h0C, 8'h3B, 8'h3C,
      8'h6B, 8'h6C, 8'hBB, 8'hBC: opcodeUnits = 2'd1;
      8'hEB, 8'hEC:               opcodeUnits = 2'd3;
      default:                    opcodeUnits = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/injCtrl.sv
module injCtrl
  import injPkg::*;
#(
  parameter int ADDR_SHORT = 3,
  parameter int ADDR_LONG  = 4,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csWrite,
  input  logic              ceStop,
  input  logic              extAddr,
  input  logic [7:0]        dummyByte,
  input  logic              accept,
  input  logic [7:0]        opByte,
  input  logic [SIZE_W-1:0] wrSize,
  output injStrobe_t        strobe
);
  localparam logic [IDX_W-1:0] LIMIT_SHORT = IDX_W'(ADDR_SHORT + 1);
  localparam logic [IDX_W-1:0] LIMIT_LONG  = IDX_W'(ADDR_LONG + 1);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] pend;
  logic [IDX_W-1:0] limit;
  logic [1:0]       units;
  logic             atLimit;

  assign limit   = extAddr ? LIMIT_LONG : LIMIT_SHORT;
  assign units   = opcodeUnits(opByte);
  assign atLimit = active && (idx != '0) && (idx >= limit);

  always_comb begin
    strobe            = '0;
    strobe.size       = wrSize;
    strobe.fill       = dummyByte;
    strobe.count      = pend;
    if (accept) begin
      if (atLimit) strobe.loadInject = 1'b1;
      else         strobe.loadPass   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      idx    <= '0;
      pend   <= '0;
    end else if (csWrite) begin
      active <= !ceStop;
      idx    <= '0;
      pend   <= '0;
    end else if (accept && active) begin
      if (idx == '0) begin
        if (units == 2'd0) begin
          active <= 1'b0;
        end else begin
          pend <= CNT_W'(units) * CNT_W'(DUMMY_MULT);
          idx  <= IDX_W'(wrSize);
        end
      end else if (atLimit) begin
        active <= 1'b0;
        pend   <= '0;
      end else begin
        idx <= idx + IDX_W'(wrSize);
      end
    end
  end
endmodule

// File: rtl/injData.sv
module injData
  import injPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txReady,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              busy
);
  logic [DATA_W-1:0] word;
  logic [SIZE_W-1:0] passLeft;
  logic [CNT_W-1:0]  dumLeft;
  logic [7:0]        fill;
  logic              inject;

  assign inject  = (dumLeft != '0);
  assign txValid = inject || (passLeft != '0);
  assign busy    = txValid;
  assign txByte  = inject ? fill : word[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word     <= '0;
      passLeft <= '0;
      dumLeft  <= '0;
      fill     <= '0;
    end else if (strobe.loadPass) begin
      word     <= wrData;
      passLeft <= strobe.size;
    end else if (strobe.loadInject) begin
      dumLeft  <= strobe.count;
      fill     <= strobe.fill;
    end else if (txValid && txReady) begin
      if (inject) begin
        dumLeft <= dumLeft - 1'b1;
      end else begin
        word     <= word >> 8;
        passLeft <= passLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiDummyInject.sv
module spiDummyInject
  import injPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csWrite,
  input  logic              ceStop,
  input  logic              extAddr,
  input  logic [7:0]        dummyByte,
  input  logic              wrValid,
  input  logic [31:0]       wrData,
  input  logic [SIZE_W-1:0] wrSize,
  output logic              wrReady,
  output logic              swallow,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txReady
);
  injStrobe_t strobe;
  logic       busy;
  logic       accept;

  assign wrReady = !busy && !csWrite;
  assign accept  = wrValid && wrReady;
  assign swallow = strobe.loadInject;

  injCtrl #(.ADDR_SHORT(3), .ADDR_LONG(4), .IDX_W(4)) ctrlInst (
    .clk(clk), .rstN(rstN), .csWrite(csWrite), .ceStop(ceStop),
    .extAddr(extAddr), .dummyByte(dummyByte), .accept(accept),
    .opByte(wrData[7:0]), .wrSize(wrSize), .strobe(strobe)
  );

  injData #(.DATA_W(32)) dataInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .txReady(txReady), .txValid(txValid), .txByte(txByte), .busy(busy)
  );
endmodule

// File: rtl/spiDummyInject_chk.sv
module spiDummyInject_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csWrite,
  input logic       ceStop,
  input logic [7:0] dummyByte,
  input logic       wrValid,
  input logic [2:0] wrSize,
  input logic       wrReady,
  input logic       swallow,
  input logic       txValid,
  input logic [7:0] txByte,
  input logic       txReady
);
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrSize >= 3'd1 && wrSize <= 3'd4)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte))); // R8
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !wrReady); // R8
  AST_INJECT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    swallow |=> (txValid && txByte == $past(dummyByte))); // R7
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (csWrite && ceStop) |=> !swallow); // R3
endmodule

bind spiDummyInject spiDummyInject_chk chkInst (
  .clk(clk), .rstN(rstN), .csWrite(csWrite), .ceStop(ceStop),
  .dummyByte(dummyByte), .wrValid(wrValid), .wrSize(wrSize),
  .wrReady(wrReady), .swallow(swallow), .txValid(txValid),
  .txByte(txByte), .txReady(txReady)
);

// File: tb/spiDummyInject_test.sv
module spiDummyInject_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csWrite = 1'b0;
  logic        ceStop = 1'b1;
  logic        extAddr = 1'b0;
  logic [7:0]  dummyByte = 8'h00;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0]  wrSize = 3'd1;
  logic        wrReady, swallow, txValid;
  logic [7:0]  txByte;
  logic        txReady = 1'b1;
  logic        throttle = 1'b0;
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  logic [7:0]  got[$];
  logic [7:0]  exp[$];

  always #2 clk = ~clk;

  spiDummyInject uut (
    .clk(clk), .rstN(rstN), .csWrite(csWrite), .ceStop(ceStop),
    .extAddr(extAddr), .dummyByte(dummyByte), .wrValid(wrValid),
    .wrData(wrData), .wrSize(wrSize), .wrReady(wrReady),
    .swallow(swallow), .txValid(txValid), .txByte(txByte),
    .txReady(txReady)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    txReady = throttle ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk) if (rstN && txValid && txReady) got.push_back(txByte);

  task automatic check(input string tag, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input int sz, output bit sw);
    wrData = d; wrSize = 3'(sz); wrValid = 1'b1;
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    sw = swallow;
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic passW(input logic [31:0] d, input int sz, input string tag);
    bit sw;
    doWrite(d, sz, sw);
    check({tag, " no swallow"}, sw, 0);
    for (int i = 0; i < sz; i++) exp.push_back(d[8*i +: 8]);
  endtask

  task automatic swallowW(input logic [31:0] d, input int n, input string tag);
    bit sw;
    doWrite(d, 1, sw);
    check({tag, " swallow"}, sw, 1);
    for (int i = 0; i < n; i++) exp.push_back(dummyByte);
  endtask

  task automatic csEv(input logic stop);
    csWrite = 1'b1; ceStop = stop;
    @(posedge clk); #1;
    csWrite = 1'b0;
  endtask

  task automatic drainCompare(input string tag);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!txValid) break;
    end
    @(posedge clk); #1;
    check({tag, " byte count"}, got.size(), exp.size());
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      check($sformatf("%s byte %0d", tag, i), got[i], exp[i]);
    got.delete(); exp.delete();
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 txValid at reset", txValid, 0);
    check("R1 wrReady at reset", wrReady, 1);
    check("R1 swallow at reset", swallow, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    dummyByte = 8'hA5;
    passW(32'h0000000B, 1, "R1 unarmed opcode");
    passW(32'h00030201, 3, "R1 unarmed addr");
    passW(32'h000000FF, 1, "R1 unarmed next");
    drainCompare("R1 unarmed");
  endtask

  task automatic tPassOrder();
    passW(32'h44332211, 4, "R2 four");
    passW(32'h0000AABB, 2, "R2 two");
    passW(32'h00C0FFEE, 3, "R2 three");
    drainCompare("R2 order");
  endtask

  task automatic tFastRead();
    extAddr = 1'b0; dummyByte = 8'hA5;
    csEv(1'b0);
    passW(32'h0000000B, 1, "R9 opcode");
    passW(32'h00000012, 1, "R6 a0");
    passW(32'h00000034, 1, "R6 a1");
    passW(32'h00000056, 1, "R6 a2");
    swallowW(32'h000000FF, 8, "R7 fast read");
    passW(32'h00000077, 1, "R7 after off");
    drainCompare("R5 fast read");
  endtask

  task automatic tQuadExt();
    extAddr = 1'b1; dummyByte = 8'h5A;
    csEv(1'b0);
    passW(32'h332211EC, 4, "R9 packed opcode");
    passW(32'h00000044, 1, "R6 ext fifth");
    swallowW(32'h00000000, 24, "R5 quad io");
    passW(32'h0000BEEF, 2, "R7 after quad");
    drainCompare("R5 quad ext");
    extAddr = 1'b0;
  endtask

  task automatic tNoDummy();
    logic [7:0] ops [0:6] = '{8'h03, 8'h13, 8'h02, 8'h12, 8'h32, 8'h34, 8'h9F};
    for (int j = 0; j < 7; j++) begin
      csEv(1'b0);
      passW({24'h0, ops[j]}, 1, "R4 opcode");
      passW(32'h00030201, 3, "R4 addr");
      passW(32'h000000AA, 1, "R4 beyond");
      passW(32'h000000BB, 1, "R4 beyond2");
    end
    drainCompare("R4 no dummy");
  endtask

  task automatic tStop();
    csEv(1'b0);
    passW(32'h0000000B, 1, "R3 opcode");
    csEv(1'b1);
    passW(32'h00030201, 3, "R3 addr");
    passW(32'h000000CC, 1, "R3 disarmed");
    passW(32'h000000DD, 1, "R3 disarmed2");
    drainCompare("R3 stop");
  endtask

  task automatic tPacked();
    extAddr = 1'b0; dummyByte = 8'h3C;
    csEv(1'b0);
    passW(32'h2211006B, 4, "R6 packed 3-byte");
    swallowW(32'h00000001, 8, "R6 packed limit");
    drainCompare("R6 packed");
  endtask

  task automatic tBackpressure();
    throttle = 1'b1; dummyByte = 8'hC3;
    csEv(1'b0);
    passW(32'h0302013B, 4, "R8 opcode+addr");
    @(negedge clk);
    check("R8 txValid pending", txValid, 1);
    check("R8 wrReady low while pending", wrReady, 0);
    @(posedge clk); #1;
    swallowW(32'h00000000, 8, "R8 inject throttled");
    passW(32'hDDCCBBAA, 4, "R8 pass throttled");
    drainCompare("R8 throttled");
    throttle = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    tPassOrder();
    tFastRead();
    tQuadExt();
    tNoDummy();
    tStop();
    tPacked();
    tBackpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule